// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers interrupt events from a group of peripheral sources and offers one of them at a time to a processor. Each source signals an event with a pulse one clock long. The block captures that pulse in a sticky pending bit, which stays set until the processor services it or software clears it. Software can also raise a pending bit on its own through a set register. This lets code trigger any interrupt without help from the hardware.

Each source has a two-bit configuration field. The field either disables the source or gives it one of three priority levels. The controller looks at every pending bit whose source is enabled. It picks the one at the highest level, and among sources at that level it picks the lowest index. It registers the result as a pending flag and a source index. The flag is held low while the global enable is off. When the processor acknowledges, the pending bit of the presented source is cleared. After that, the next winner is presented.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source i is configured by `lvl_cfg[2i+1:2i]`. The value 00 disables the source, and 01, 10 and 11 select level 1, 2 and 3. A pending source with field 00 is never presented.
- R2: A pending enabled source at a higher level is always presented ahead of any source at a lower level, whatever their indices.
- R3: Among pending enabled sources at the same level, the one with the lowest index is presented.
- R4: A one-cycle pulse on `src_pulse[i]` sets `pend_bits[i]` at the next edge. The bit then stays set until it is cleared.
- R5: When `ack` is high while `irq_out` is high, bit `irq_id` of the pending register clears at the next edge. The next winner is then presented.
- R6: When `clr_wr` is high, each 1 in `clr_data` clears the matching pending bit. Each 0 leaves its bit unchanged.
- R7: When `set_wr` is high, each 1 in `set_data` sets the matching pending bit.
- R8: While `glb_en` is low, `irq_out` is 0 and `irq_id` is 0 from the next edge on. The pending bits are kept.
- R9: Suppose a hardware pulse or a software set hits the same bit as a clear write or an acknowledge in the same cycle. The bit ends up set.
- R10: After reset, `pend_bits`, `irq_out` and `irq_id` are 0. `irq_out` and `irq_id` are registered, so they follow a change of `pend_bits` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| lvl_cfg | input | 2*N_SRC | Per-source enable/level fields, two bits per source |
| src_pulse | input | N_SRC | One-cycle request pulses from the sources |
| set_wr | input | 1 | Write strobe for the request-set register |
| set_data | input | N_SRC | Bits to set (1 = set) |
| clr_wr | input | 1 | Write strobe for the request clear |
| clr_data | input | N_SRC | Bits to clear (1 = clear) |
| ack | input | 1 | Processor acknowledge of the presented source |
| pend_bits | output | N_SRC | Pending request register |
| irq_out | output | 1 | An enabled request is pending and presented |
| irq_id | output | $clog2(N_SRC) | Index of the presented source |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is a source pulse arriving in the very cycle that an acknowledge or a clear write removes the same bit. The other is the one-cycle gap in which the pending register has already changed but the registered winner has not. The bench steers into these by driving the pulse, the acknowledge and the clear on one shared falling edge. It then samples both the pending bits and the registered outputs on each of the following falling edges. Every combination of level fields and pending patterns for a four-source configuration is loaded through the set register. The presented winner is compared against a score computed in the bench.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_HIGH = 2'd3
    } lvl_e;
endpackage

// File: rtl/irqc_req_reg.sv
`timescale 1ns/1ps
// Sticky pending-request register: sets dominate clears.
module irqc_req_reg #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic [N_SRC-1:0] set_mask,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] pend_q
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then apply sets so that no event is lost
        st_d.pend = (st_q.pend & ~clr_mask) | src_pulse | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    // R4: a pulse is captured at the next edge
    a_r4_pulse_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

    // R7 / R9: a software set is captured even if cleared in the same cycle
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

    // R6: a clear without a competing set empties the bit
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_mask) && !(|(set_mask | src_pulse))) |=> ((pend_q & $past(clr_mask)) == '0));

    // R4: without a clear, a pending bit is never lost
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
// Level-then-index winner selection over the pending bits.
module irqc_arbiter #(
    parameter int N_SRC = 8,
    parameter int ID_W  = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]                 pend,
    input  logic [N_SRC*irqc_pkg::LVL_W-1:0] lvl_cfg,
    output logic                             found,
    output logic [ID_W-1:0]                  win_id
);
    import irqc_pkg::*;

    logic [LVL_W-1:0] lvl_a [N_SRC];
    logic [LVL_W-1:0] best_lvl;

    for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
        assign lvl_a[g] = lvl_cfg[g*LVL_W +: LVL_W];
    end

    always_comb begin
        best_lvl = LVL_OFF;
        win_id   = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (lvl_a[i] > best_lvl)) begin
                best_lvl = lvl_a[i];
                win_id   = ID_W'(i);
            end
        end
        found = (best_lvl != LVL_OFF);
    end

    always_comb begin
        if (found) begin
            a_r1_winner_enabled: assert (pend[win_id] && (lvl_a[win_id] != LVL_OFF));
        end
        for (int i = 0; i < N_SRC; i++) begin
            if (found && pend[i]) begin
                a_r2_no_higher_level: assert (lvl_a[i] <= lvl_a[win_id]);
                a_r3_lowest_index_on_tie: assert (!((lvl_a[i] == lvl_a[win_id]) && (ID_W'(i) < win_id)));
            end
            if (!found) begin
                a_r1_none_missed: assert (!(pend[i] && (lvl_a[i] != LVL_OFF)));
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
    parameter int N_SRC = 8,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   glb_en,
    input  logic [2*N_SRC-1:0]     lvl_cfg,
    input  logic [N_SRC-1:0]       src_pulse,
    input  logic                   set_wr,
    input  logic [N_SRC-1:0]       set_data,
    input  logic                   clr_wr,
    input  logic [N_SRC-1:0]       clr_data,
    input  logic                   ack,
    output logic [N_SRC-1:0]       pend_bits,
    output logic                   irq_out,
    output logic [ID_W-1:0]        irq_id
);
    typedef struct packed {
        logic            irq;
        logic [ID_W-1:0] id;
    } out_t;

    out_t             out_d, out_q;
    logic [N_SRC-1:0] set_mask, clr_mask, ack_mask;
    logic             found;
    logic [ID_W-1:0]  win_id;

    assign set_mask = set_wr ? set_data : '0;
    assign ack_mask = (ack && out_q.irq) ? (N_SRC'(1) << out_q.id) : '0;
    assign clr_mask = (clr_wr ? clr_data : '0) | ack_mask;

    irqc_req_reg #(.N_SRC(N_SRC)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .pend_q    (pend_bits)
    );

    irqc_arbiter #(.N_SRC(N_SRC), .ID_W(ID_W)) u_arb (
        .pend    (pend_bits),
        .lvl_cfg (lvl_cfg),
        .found   (found),
        .win_id  (win_id)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = glb_en && found;
        out_d.id  = (glb_en && found) ? win_id : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_out = out_q.irq;
    assign irq_id  = out_q.id;

    // R8: global enable low silences the output at the next edge
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (!irq_out && (irq_id == '0)));

    // R10: an asserted output follows a nonzero pending register one cycle earlier
    a_r10_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(pend_bits) != '0));

    // R5: acknowledge clears the presented source when nothing sets it again
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !set_wr && (src_pulse == '0)) |=> !pend_bits[$past(irq_id)]);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    localparam int N  = 4;
    localparam int IW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           glb_en = 1'b0;
    logic [2*N-1:0] lvl_cfg = '0;
    logic [N-1:0]   src_pulse = '0;
    logic           set_wr = 1'b0;
    logic [N-1:0]   set_data = '0;
    logic           clr_wr = 1'b0;
    logic [N-1:0]   clr_data = '0;
    logic           ack = 1'b0;
    logic [N-1:0]   pend_bits;
    logic           irq_out;
    logic [IW-1:0]  irq_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .lvl_cfg(lvl_cfg),
        .src_pulse(src_pulse), .set_wr(set_wr), .set_data(set_data),
        .clr_wr(clr_wr), .clr_data(clr_data), .ack(ack),
        .pend_bits(pend_bits), .irq_out(irq_out), .irq_id(irq_id)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic nedge(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // score = level*N + (N-1-index); the largest positive score wins
    function automatic int exp_winner(input int p, input int cfg);
        int best = 0;
        int id = -1;
        for (int i = 0; i < N; i++) begin
            int lv = (cfg >> (2*i)) & 3;
            int sc = lv * N + (N - 1 - i);
            if (((p >> i) & 1) && lv != 0 && sc > best) begin
                best = sc;
                id = i;
            end
        end
        return id;
    endfunction

    task automatic wipe();
        clr_wr = 1'b1; clr_data = '1;
        nedge();
        clr_wr = 1'b0; clr_data = '0;
        nedge();
    endtask

    initial begin
        nedge(3);
        // R10: reset state
        check("R10 reset pend", int'(pend_bits), 0);
        check("R10 reset irq", int'(irq_out), 0);
        check("R10 reset id", int'(irq_id), 0);
        rst_n = 1'b1;
        glb_en = 1'b1;
        nedge();

        // R1 R2 R3 R7: every level configuration against every pending pattern
        for (int cfg = 0; cfg < 256; cfg++) begin
            for (int p = 0; p < 16; p++) begin
                int w;
                lvl_cfg = 8'(cfg);
                set_wr = 1'b1; set_data = 4'(p);
                nedge();
                set_wr = 1'b0; set_data = '0;
                check("R7 set register", int'(pend_bits), p);
                nedge();
                w = exp_winner(p, cfg);
                check("R1 R2 R3 irq", int'(irq_out), (w >= 0) ? 1 : 0);
                check("R1 R2 R3 id", int'(irq_id), (w >= 0) ? w : 0);
                wipe();
            end
        end

        // R10: one-cycle lag between pending register and outputs
        lvl_cfg = 8'b01_01_01_01;
        set_wr = 1'b1; set_data = 4'b0100;
        nedge();
        set_wr = 1'b0; set_data = '0;
        check("R10 pend updated", int'(pend_bits), 4);
        check("R10 irq still low", int'(irq_out), 0);
        nedge();
        check("R10 irq one cycle later", int'(irq_out), 1);
        check("R10 id one cycle later", int'(irq_id), 2);
        wipe();

        // R4: single pulse captured and held
        src_pulse = 4'b1000;
        nedge();
        src_pulse = '0;
        nedge(4);
        check("R4 pulse held", int'(pend_bits), 8);
        check("R4 pulse presented", int'(irq_id), 3);

        // R5: acknowledge clears the winner, next one is presented
        set_wr = 1'b1; set_data = 4'b0010;
        nedge();
        set_wr = 1'b0; set_data = '0;
        nedge();
        check("R5 first winner", int'(irq_id), 1);
        ack = 1'b1;
        nedge();
        ack = 1'b0;
        check("R5 ack cleared bit", int'(pend_bits), 8);
        nedge();
        check("R5 next winner", int'(irq_id), 3);
        check("R5 still pending", int'(irq_out), 1);

        // R6: zeros in a clear write leave bits alone, ones clear
        clr_wr = 1'b1; clr_data = 4'b0000;
        nedge();
        clr_wr = 1'b0;
        check("R6 clear zero no effect", int'(pend_bits), 8);
        clr_wr = 1'b1; clr_data = 4'b1000;
        nedge();
        clr_wr = 1'b0; clr_data = '0;
        check("R6 clear one", int'(pend_bits), 0);
        nedge();
        check("R6 irq drops", int'(irq_out), 0);

        // R9: pulse and clear on the same bit in the same cycle
        src_pulse = 4'b0001; clr_wr = 1'b1; clr_data = 4'b0001;
        nedge();
        src_pulse = '0; clr_wr = 1'b0; clr_data = '0;
        check("R9 pulse beats clear", int'(pend_bits), 1);
        nedge();
        // R9: pulse collides with acknowledge of the same source
        check("R9 source 0 presented", int'(irq_id), 0);
        ack = 1'b1; src_pulse = 4'b0001;
        nedge();
        ack = 1'b0; src_pulse = '0;
        check("R9 pulse beats ack", int'(pend_bits), 1);
        // R9: software set and clear on the same bit
        set_wr = 1'b1; set_data = 4'b0100; clr_wr = 1'b1; clr_data = 4'b0101;
        nedge();
        set_wr = 1'b0; set_data = '0; clr_wr = 1'b0; clr_data = '0;
        check("R9 set beats clear", int'(pend_bits), 4);

        // R8: global enable gates the output, pending bits are kept
        glb_en = 1'b0;
        nedge();
        check("R8 irq gated", int'(irq_out), 0);
        check("R8 id gated", int'(irq_id), 0);
        check("R8 pending kept", int'(pend_bits), 4);
        glb_en = 1'b1;
        nedge();
        check("R8 irq restored", int'(irq_out), 1);
        check("R8 id restored", int'(irq_id), 2);

        // R1: pending but disabled source is never presented
        lvl_cfg = 8'b01_00_01_01;
        nedge(2);
        check("R1 disabled source", int'(irq_out), 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule